// File: doc/BRIEF.md
# Timed Configuration Byte Access Controller

This block sits beside a small processor core and gives software a way to read the factory configuration bytes and to program the boot protection bits. Software first writes a control value with two enable bits set. That opens a short window, counted in clock cycles. A program-memory load issued inside the window returns a configuration byte instead of program memory. The 16-bit address pointer picks the byte: the protection byte or one of two option bytes. A store issued inside the window clears boot protection bits, using a data byte supplied by the core.

The enables drop by themselves when an access completes or when the window runs out. A write to non-volatile data memory in progress holds the whole mechanism off. Protection bits can only move from 1 (unprogrammed) to 0 (programmed). A load that does not qualify passes the normal program-memory byte through.

Top module: `cfg_access_ctrl`

## Requirements
- R1: After reset, `rd_data` is 0x00, `armed` is 0 and `lock_byte` equals {2'b11, LOCK_INIT}, which is 0xFF with default parameters.
- R2: A control write sets `armed` on the next clock edge only when bit 0 and bit 3 of `ctl_wdata` are both 1. A control write without both bits leaves `armed` at 0 and also clears it if it was set.
- R3: A load counts as qualified when `ld_strobe` is high in one of the first three cycles after arming. On the edge that samples it, `rd_data` takes a configuration byte chosen by `ptr`:
  - 0x0001 gives `lock_byte`.
  - 0x0000 gives FUSE_LO_INIT (default 0xE1).
  - 0x0003 gives FUSE_HI_INIT (default 0x99).
  - Any other pointer gives 0xFF.
- R4: A load in the fourth cycle after arming, or a load while not armed, puts `pmem_data` into `rd_data`. When `ld_strobe` is low, `rd_data` holds its value.
- R5: A store (`st_strobe`) in any of the first four cycles after arming sets `lock_byte[5:2]` to `lock_byte[5:2] & src_data[5:2]`. Bits 1..0 and 7..6 of `lock_byte` stay unchanged, and `ptr` is ignored.
- R6: A store while not armed, or after the window has closed, leaves `lock_byte` unchanged.
- R7: Programming never turns a 0 bit of `lock_byte` back into 1.
- R8: `armed` falls on the edge after a qualified load or store. If no access qualifies, `armed` stays high for exactly four cycles after arming and then falls.
- R9: While `ee_busy` is 1:
  - Control writes are ignored.
  - Loads return `pmem_data`.
  - Stores leave `lock_byte` unchanged.
- R10: A store and a load in the same armed cycle perform the store. The load then returns `pmem_data`, and the window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data (bit 0 and bit 3 are the enables) |
| ld_strobe | input | 1 | Program-memory load in this cycle |
| st_strobe | input | 1 | Program-memory store in this cycle |
| ptr | input | 16 | Address pointer |
| src_data | input | 8 | Data byte used for protection programming |
| pmem_data | input | 8 | Normal program-memory read byte |
| ee_busy | input | 1 | Non-volatile data memory write in progress |
| rd_data | output | 8 | Load result, registered |
| lock_byte | output | 8 | Current protection byte as read back |
| armed | output | 1 | Special access window open |

## Verification
A load and a store can reach the controller in the same armed cycle. The bench provokes this by raising both strobes in the first window cycle, with pointer 0x0000 and a programming byte that clears two boot bits. It then judges the result at the ports:
- `lock_byte` must show the AND result.
- `rd_data` must carry the pass-through program byte rather than the option byte.
- `armed` must be low on the following cycle.

The end of the load window, against the still-open store window, is probed separately by loading and storing in the third and fourth cycles.

// File: rtl/cfg_access_pkg.sv
package cfg_access_pkg;
  localparam int unsigned EN_STORE_BIT = 0;
  localparam int unsigned EN_CFGSEL_BIT = 3;
  localparam logic [15:0] PTR_OPT_LO = 16'h0000;
  localparam logic [15:0] PTR_PROT = 16'h0001;
  localparam logic [15:0] PTR_OPT_HI = 16'h0003;

  typedef enum logic [1:0] {
    SEL_OPT_LO = 2'd0,
    SEL_PROT   = 2'd1,
    SEL_OPT_HI = 2'd2,
    SEL_NONE   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/cfg_window.sv
module cfg_window #(
  parameter int unsigned LD_WIN = 3,
  parameter int unsigned ST_WIN = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [DW-1:0] ctl_wdata,
  input  logic          ld_strobe,
  input  logic          st_strobe,
  input  logic          ee_busy,
  output logic          armed,
  output logic          ld_hit,
  output logic          st_hit
);
  import cfg_access_pkg::*;

  localparam int unsigned CW = $clog2(ST_WIN + 1);
  localparam logic [CW-1:0] LD_LAST = CW'(LD_WIN);
  localparam logic [CW-1:0] ST_LAST = CW'(ST_WIN);

  logic          armed_q, armed_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          wr_ok, arm_req, upd_en;
  logic          unused_wdata;

  assign unused_wdata = ^ctl_wdata;

  always_comb begin
    wr_ok   = ctl_wr & ~ee_busy;
    arm_req = wr_ok & ctl_wdata[EN_STORE_BIT] & ctl_wdata[EN_CFGSEL_BIT];
    st_hit  = armed_q & st_strobe & ~ee_busy & (cnt_q <= ST_LAST);
    ld_hit  = armed_q & ld_strobe & ~ee_busy & (cnt_q <= LD_LAST) & ~st_hit;
  end

  always_comb begin
    armed_n = armed_q;
    cnt_n   = cnt_q;
    upd_en  = wr_ok | armed_q;
    if (wr_ok) begin
      armed_n = arm_req;
      cnt_n   = arm_req ? CW'(1) : '0;
    end else if (armed_q) begin
      if (ld_hit || st_hit || (cnt_q >= ST_LAST)) begin
        armed_n = 1'b0;
        cnt_n   = '0;
      end else begin
        cnt_n = CW'(cnt_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (upd_en) begin
      armed_q <= armed_n;
      cnt_q   <= cnt_n;
    end
  end

  assign armed = armed_q;

  AST_ARM_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(ctl_wr && !ee_busy && ctl_wdata[EN_STORE_BIT] && ctl_wdata[EN_CFGSEL_BIT])); // R2
  AST_CLOSE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hit || st_hit) && !ctl_wr |=> !armed_q); // R8
  AST_BUSY_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    ee_busy && !armed_q |=> !armed_q); // R9
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && st_hit)); // R10
endmodule

// File: rtl/cfg_lock_store.sv
module cfg_lock_store #(
  parameter int unsigned DW = 8,
  parameter logic [5:0] LOCK_INIT = 6'h3F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_hit,
  input  logic [DW-1:0] src_data,
  output logic [DW-1:0] lock_byte
);
  logic [5:0] prot_q, prot_n;
  logic       unused_src;

  assign unused_src = ^{src_data[DW-1:6], src_data[1:0]};

  always_comb begin
    prot_n = {prot_q[5:2] & src_data[5:2], prot_q[1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prot_q <= LOCK_INIT;
    else if (st_hit) prot_q <= prot_n;
  end

  assign lock_byte = {{(DW-6){1'b1}}, prot_q};

  AST_PROT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q & ~$past(prot_q)) == 6'd0); // R7
  AST_PROT_ONLY_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(st_hit) |-> $stable(prot_q)); // R6
  AST_GENERAL_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(prot_q[1:0])); // R5
endmodule

// File: rtl/cfg_read_path.sv
module cfg_read_path #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 16,
  parameter logic [DW-1:0] FUSE_LO_INIT = 8'hE1,
  parameter logic [DW-1:0] FUSE_HI_INIT = 8'h99
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_strobe,
  input  logic          ld_hit,
  input  logic [AW-1:0] ptr,
  input  logic [DW-1:0] lock_byte,
  input  logic [DW-1:0] pmem_data,
  output logic [DW-1:0] rd_data
);
  import cfg_access_pkg::*;

  cfg_sel_e      sel;
  logic [DW-1:0] cfg_byte, rd_n, rd_q;
  logic          rd_en;

  always_comb begin
    if (ptr == AW'(PTR_OPT_LO))      sel = SEL_OPT_LO;
    else if (ptr == AW'(PTR_PROT))   sel = SEL_PROT;
    else if (ptr == AW'(PTR_OPT_HI)) sel = SEL_OPT_HI;
    else                             sel = SEL_NONE;
  end

  always_comb begin
    unique case (sel)
      SEL_OPT_LO: cfg_byte = FUSE_LO_INIT;
      SEL_PROT:   cfg_byte = lock_byte;
      SEL_OPT_HI: cfg_byte = FUSE_HI_INIT;
      default:    cfg_byte = '1;
    endcase
  end

  always_comb begin
    rd_en = ld_strobe;
    rd_n  = ld_hit ? cfg_byte : pmem_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_n;
  end

  assign rd_data = rd_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ld_strobe) |-> $stable(rd_q)); // R4
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    ld_strobe && !ld_hit |=> rd_q == $past(pmem_data)); // R4
endmodule

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 16,
  parameter int unsigned LD_WIN = 3,
  parameter int unsigned ST_WIN = 4,
  parameter logic [5:0] LOCK_INIT = 6'h3F,
  parameter logic [7:0] FUSE_LO_INIT = 8'hE1,
  parameter logic [7:0] FUSE_HI_INIT = 8'h99
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [DW-1:0] ctl_wdata,
  input  logic          ld_strobe,
  input  logic          st_strobe,
  input  logic [AW-1:0] ptr,
  input  logic [DW-1:0] src_data,
  input  logic [DW-1:0] pmem_data,
  input  logic          ee_busy,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] lock_byte,
  output logic          armed
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       ld_hit, st_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cfg_window #(.LD_WIN(LD_WIN), .ST_WIN(ST_WIN), .DW(DW)) u_window (
    .clk(clk), .rst_n(rst_int_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ld_strobe(ld_strobe), .st_strobe(st_strobe), .ee_busy(ee_busy),
    .armed(armed), .ld_hit(ld_hit), .st_hit(st_hit)
  );

  cfg_lock_store #(.DW(DW), .LOCK_INIT(LOCK_INIT)) u_lock (
    .clk(clk), .rst_n(rst_int_n), .st_hit(st_hit), .src_data(src_data),
    .lock_byte(lock_byte)
  );

  cfg_read_path #(.DW(DW), .AW(AW), .FUSE_LO_INIT(DW'(FUSE_LO_INIT)),
                  .FUSE_HI_INIT(DW'(FUSE_HI_INIT))) u_read (
    .clk(clk), .rst_n(rst_int_n), .ld_strobe(ld_strobe), .ld_hit(ld_hit),
    .ptr(ptr), .lock_byte(lock_byte), .pmem_data(pmem_data), .rd_data(rd_data)
  );
endmodule

// File: tb/sim_cfg_access_ctrl.sv
`timescale 1ns/1ps
module sim_cfg_access_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_wr, ld_strobe, st_strobe, ee_busy;
  logic [7:0]  ctl_wdata, src_data, pmem_data;
  logic [15:0] ptr;
  logic [7:0]  rd_data, lock_byte;
  logic        armed;
  int nvec = 0;
  int nerr = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cfg_access_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ld_strobe(ld_strobe), .st_strobe(st_strobe), .ptr(ptr),
    .src_data(src_data), .pmem_data(pmem_data), .ee_busy(ee_busy),
    .rd_data(rd_data), .lock_byte(lock_byte), .armed(armed)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [7:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wdata = 8'h00;
  endtask

  task automatic do_load(input logic [15:0] p, input logic [7:0] pm);
    ld_strobe = 1'b1; ptr = p; pmem_data = pm;
    @(negedge clk);
    ld_strobe = 1'b0;
  endtask

  task automatic do_store(input logic [7:0] s, input logic [15:0] p);
    st_strobe = 1'b1; src_data = s; ptr = p;
    @(negedge clk);
    st_strobe = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 armed", {7'd0, armed}, 8'h00);
    check("R1 lock_byte", lock_byte, 8'hFF);
  endtask

  task automatic t_arm;
    ctl_write(8'h01); check("R2 bit0 only", {7'd0, armed}, 8'h00);
    ctl_write(8'h08); check("R2 bit3 only", {7'd0, armed}, 8'h00);
    ctl_write(8'h09); check("R2 both bits", {7'd0, armed}, 8'h01);
    ctl_write(8'h08); check("R2 disarm write", {7'd0, armed}, 8'h00);
    ctl_write(8'h09);
    idle(3); check("R8 still armed cycle4", {7'd0, armed}, 8'h01);
    idle(1); check("R8 expired", {7'd0, armed}, 8'h00);
  endtask

  task automatic t_read;
    ctl_write(8'h09); do_load(16'h0000, 8'h5A);
    check("R3 opt lo", rd_data, 8'hE1);
    check("R8 closed after load", {7'd0, armed}, 8'h00);
    ctl_write(8'h09); idle(2); do_load(16'h0003, 8'h5A);
    check("R3 opt hi cycle3", rd_data, 8'h99);
    ctl_write(8'h09); do_load(16'h0002, 8'h5A);
    check("R3 other ptr", rd_data, 8'hFF);
    ctl_write(8'h09); idle(3); do_load(16'h0000, 8'h5A);
    check("R4 load cycle4", rd_data, 8'h5A);
    do_load(16'h0001, 8'h3C);
    check("R4 unarmed load", rd_data, 8'h3C);
    pmem_data = 8'h77; idle(2);
    check("R4 hold", rd_data, 8'h3C);
  endtask

  task automatic t_store;
    ctl_write(8'h09); idle(3); do_store(8'hF4, 16'h1234);
    check("R5 store cycle4", lock_byte, 8'hF7);
    check("R8 closed after store", {7'd0, armed}, 8'h00);
    ctl_write(8'h09); idle(4); do_store(8'h00, 16'h0001);
    check("R6 store after window", lock_byte, 8'hF7);
    do_store(8'h00, 16'h0001);
    check("R6 unarmed store", lock_byte, 8'hF7);
    ctl_write(8'h09); do_store(8'hFF, 16'h0001);
    check("R7 no set back", lock_byte, 8'hF7);
    ctl_write(8'h09); do_load(16'h0001, 8'h00);
    check("R3 prot readback", rd_data, 8'hF7);
  endtask

  task automatic t_busy;
    ee_busy = 1'b1; ctl_write(8'h09);
    check("R9 write blocked", {7'd0, armed}, 8'h00);
    ee_busy = 1'b0; ctl_write(8'h09); ee_busy = 1'b1;
    do_load(16'h0000, 8'h42);
    check("R9 load blocked", rd_data, 8'h42);
    do_store(8'hC3, 16'h0001);
    check("R9 store blocked", lock_byte, 8'hF7);
    ee_busy = 1'b0; idle(3);
  endtask

  task automatic t_collide;
    ctl_write(8'h09);
    ld_strobe = 1'b1; st_strobe = 1'b1; ptr = 16'h0000;
    src_data = 8'hE7; pmem_data = 8'h6B;
    @(negedge clk);
    ld_strobe = 1'b0; st_strobe = 1'b0;
    check("R10 store done", lock_byte, 8'hE7);
    check("R10 load passes", rd_data, 8'h6B);
    check("R10 window closed", {7'd0, armed}, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = 8'h00; ld_strobe = 1'b0;
    st_strobe = 1'b0; ptr = 16'h0000; src_data = 8'hFF; pmem_data = 8'h00;
    ee_busy = 1'b0;
    idle(3); rst_n = 1'b1; idle(4);
    t_reset; t_arm; t_read; t_store; t_busy; t_collide;
    done = 1;
  end

  initial begin
    wait (done || cyc > 20000);
    if (!done) begin
      nvec++; nerr++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule